// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Loader

This block fills the four threshold offsets that a pair of FIFOs uses for its almost-empty and almost-full flags. FIFO1 gets an almost-full offset (`y1_ofs`) and an almost-empty offset (`x1_ofs`). FIFO2 gets the same pair (`y2_ofs`, `x2_ofs`).

Three pins choose how the offsets are filled. They are captured on the last write-port clock edge that sees the master reset low, so their level at reset release is what counts.

- **Preset:** a fixed constant goes into all four offsets.
- **Parallel:** the first four writes on the write port carry the offsets instead of FIFO data.
- **Serial:** the offsets arrive as one bitstream on a data pin, qualified by an active-low enable.

Until programming is complete, the block holds the input-ready outputs low and keeps programming writes away from the FIFO memory (`fifo_wr`). FIFO2's input-ready output lives in a second clock domain. It is raised through a two-flop synchronizer.

Top module: `ofs_prog_ctrl`

## Requirements
- R1: While `mrst_n` is low, `ir_a` and `ir_c` are driven low and `fifo_wr` stays low even with `wr_en` high.
- R2: With `spm_sel`=1, the pin pair {`fs1_sen`,`fs0_sd`} at reset release selects a preset for all four offsets: 11 gives 64, 10 gives 16, 01 gives 8. `ir_a` is low after the first write-clock edge following release and high after the second.
- R3: With `spm_sel`=1 and both select pins 0, `ir_a` is high from the first edge after release. The first four `wr_en` cycles load `wr_data_lo` into Y1, X1, Y2, X2 in that order, with `fifo_wr` held low. Later writes reach `fifo_wr`.
- R4: With `spm_sel`=0, `fs1_sen`=1 and `fs0_sd`=0 at release, serial mode is selected. One bit of `fs0_sd` is taken on each `clk_a` edge where `fs1_sen` is 0. In total 4·OFS_W bits are taken: MSB of Y1 first, then X1 and Y2, and the LSB of X2 last. Edges with `fs1_sen` high shift nothing.
- R5: In serial mode, `ir_a` stays low and `fifo_wr` stays low until the edge that takes the last bit. After that edge `fifo_wr` follows `wr_en`, and `ir_a` rises on the next `clk_a` edge.
- R6: Any encoding not listed in R2 to R4 loads 8 into all four offsets and drives `cfg_err` high. All listed encodings leave `cfg_err` low.
- R7: `ir_c` rises only after programming is complete, on the second `clk_c` edge after completion, and rises exactly once per programming session.
- R8: Once programming is complete, the offsets no longer change, including on later writes.
- R9: Changes on `spm_sel`, `fs1_sen` and `fs0_sd` after reset release do not change the mode, the offsets or `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Write-port clock (FIFO1 input side) |
| clk_c | input | 1 | FIFO2 input-side clock |
| mrst_n | input | 1 | Master reset, active low, sampled in both domains |
| spm_sel | input | 1 | Mode group select captured at reset release |
| fs0_sd | input | 1 | Select bit 0 during reset; serial data in serial mode |
| fs1_sen | input | 1 | Select bit 1 during reset; active-low shift enable in serial mode |
| wr_en | input | 1 | Write strobe on the write port |
| wr_data_lo | input | OFS_W | Low bits of the write data bus, MSB at the top |
| fifo_wr | output | 1 | Write strobe allowed through to FIFO1 memory |
| ir_a | output | 1 | FIFO1 input ready (clk_a domain) |
| ir_c | output | 1 | FIFO2 input ready (clk_c domain) |
| cfg_err | output | 1 | Reserved mode encoding was captured |
| y1_ofs | output | OFS_W | FIFO1 almost-full offset |
| x1_ofs | output | OFS_W | FIFO1 almost-empty offset |
| y2_ofs | output | OFS_W | FIFO2 almost-full offset |
| x2_ofs | output | OFS_W | FIFO2 almost-empty offset |

## Verification

**Timing of the results.**
- `fifo_wr` is combinational, so it is sampled 1 ns after the write strobe is driven.
- In preset mode `ir_a` is due two `clk_a` edges after release.
- In serial mode `ir_a` is due one edge after the edge that takes the last bit.
- `ir_c` needs two `clk_c` edges after completion. It is checked low half a `clk_a` cycle after completion and high three and a half cycles later.

**How the checks keep to that.** Inputs are driven and outputs sampled on falling edges of `clk_a`. A scoreboard queue holds the expected offsets and error flag for each session. The monitor compares them on the first falling `clk_a` edge after `ir_c` rises, which is when every offset is final.

// File: rtl/ofs_prog_pkg.sv
// Package: shared mode type, preset constants and the reset-time mode decode
// function for the offset loader. Assumes at least 7 offset bits so that all
// presets fit.
package ofs_prog_pkg;

    typedef enum logic [2:0] {
        MODE_P64,
        MODE_P16,
        MODE_P8,
        MODE_PAR,
        MODE_SER,
        MODE_RSV
    } ld_mode_e;

    localparam int unsigned PRESET_LARGE = 64;
    localparam int unsigned PRESET_MID   = 16;
    localparam int unsigned PRESET_SMALL = 8;
    localparam int unsigned OFS_SLOTS    = 4;

    // Map the three strap pins onto a load mode.
    function automatic ld_mode_e decode_mode(input logic spm, input logic fs1, input logic fs0);
        if (spm) begin
            case ({fs1, fs0})
                2'b11:   return MODE_P64;
                2'b10:   return MODE_P16;
                2'b01:   return MODE_P8;
                default: return MODE_PAR;
            endcase
        end
        if (fs1 && !fs0) return MODE_SER;
        return MODE_RSV;
    endfunction

endpackage

// File: rtl/ofs_mode_decode.sv
// Module: combinational decode of the strap pins into a load mode, the preset
// value that goes with it (zero for parallel and serial modes) and a reserved
// flag. Reserved encodings fall back to the smallest preset.
module ofs_mode_decode
    import ofs_prog_pkg::*;
#(
    parameter int OW = 9
) (
    input  logic          spm,
    input  logic          fs1,
    input  logic          fs0,
    output ld_mode_e      mode,
    output logic [OW-1:0] preset,
    output logic          rsv
);

    // Decode the pins and pick the reset value of the offsets.
    always_comb begin
        mode = decode_mode(spm, fs1, fs0);
        rsv  = (mode == MODE_RSV);
        case (mode)
            MODE_P64: preset = OW'(PRESET_LARGE);
            MODE_P16: preset = OW'(PRESET_MID);
            MODE_P8,
            MODE_RSV: preset = OW'(PRESET_SMALL);
            default:  preset = '0;
        endcase
    end

endmodule

// File: rtl/ofs_load_ctrl.sv
// Module: write-port-domain load engine. It holds the mode captured while
// reset is low, loads the offset slots (slot 0 = Y1, 1 = X1, 2 = Y2, 3 = X2)
// by preset, by parallel writes or by a serial shift chain, and produces the
// done flag, the FIFO1 input-ready and the steered write strobe.
// Assumes a synchronous active-low reset held for at least one clock edge.
module ofs_load_ctrl
    import ofs_prog_pkg::*;
#(
    parameter int OW    = 9,
    parameter int SLOTS = OFS_SLOTS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  ld_mode_e            dec_mode,
    input  logic [OW-1:0]       dec_preset,
    input  logic                dec_rsv,
    input  logic                wr_en,
    input  logic [OW-1:0]       wr_bits,
    input  logic                sd,
    input  logic                sen_n,
    output logic [SLOTS*OW-1:0] ofs_vec,
    output logic                done,
    output logic                ir,
    output logic                fifo_wr,
    output logic                cfg_err,
    output logic                par_mode
);

    localparam int TOTAL = SLOTS * OW;
    localparam int SW    = $clog2(SLOTS);
    localparam int BW    = $clog2(TOTAL + 1);

    ld_mode_e          mode_q;
    logic              err_q;
    logic              done_q;
    logic              ir_q;
    logic [SW-1:0]     slot_q;
    logic [BW-1:0]     bit_q;
    logic [OW-1:0]     slot_r [SLOTS];
    logic [SLOTS-1:0]  shift_in;
    logic              par_load;
    logic              ser_shift;
    logic              last_par;
    logic              last_ser;

    assign par_load  = (mode_q == MODE_PAR) && !done_q && wr_en;
    assign ser_shift = (mode_q == MODE_SER) && !done_q && !sen_n;
    assign last_par  = par_load  && (slot_q == SW'(SLOTS - 1));
    assign last_ser  = ser_shift && (bit_q == BW'(TOTAL - 1));

    // Track the strap decode while reset is low; freeze it at release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= dec_mode;
            err_q  <= dec_rsv;
        end
    end

    // Count parallel slots written and serial bits taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            bit_q  <= '0;
        end else begin
            if (par_load)  slot_q <= slot_q + 1'b1;
            if (ser_shift) bit_q  <= bit_q + 1'b1;
        end
    end

    // Raise done once the chosen load method has finished; it then sticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (!done_q) begin
            case (mode_q)
                MODE_PAR: done_q <= last_par;
                MODE_SER: done_q <= last_ser;
                default:  done_q <= 1'b1;
            endcase
        end
    end

    // Input-ready: open at once for parallel mode, otherwise after done.
    always_ff @(posedge clk) begin
        if (!rst_n) ir_q <= 1'b0;
        else        ir_q <= done_q || (mode_q == MODE_PAR);
    end

    // One register per offset slot, chained for serial shifting.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [OW:0] shifted;
        if (g == SLOTS - 1) begin : g_tail
            assign shift_in[g] = sd;
        end else begin : g_link
            assign shift_in[g] = slot_r[g+1][OW-1];
        end
        assign shifted = {slot_r[g], shift_in[g]};

        // Load the preset in reset, then take serial or parallel updates.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 slot_r[g] <= dec_preset;
            else if (ser_shift)                         slot_r[g] <= shifted[OW-1:0];
            else if (par_load && (slot_q == SW'(g)))    slot_r[g] <= wr_bits;
        end

        assign ofs_vec[(SLOTS-1-g)*OW +: OW] = slot_r[g];
    end

    assign done     = done_q;
    assign ir       = ir_q;
    assign fifo_wr  = wr_en && done_q && rst_n;
    assign cfg_err  = err_q;
    assign par_mode = (mode_q == MODE_PAR);

endmodule

// File: rtl/ofs_done_sync.sv
// Module: multi-flop synchronizer carrying the done level into another clock
// domain. Assumes a level that is stable once set, STAGES >= 2 and a
// synchronous active-low reset in the destination domain.
module ofs_done_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] sh;

    // Shift the foreign level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];

endmodule

// File: rtl/ofs_prog_ctrl.sv
// Module: top of the offset loader. It decodes the strap pins, runs the
// write-port load engine and brings the completion into the FIFO2 clock
// domain to raise its input-ready. Assumes mrst_n is held low for at least
// two edges of each clock and that DEPTH is a power of two of 128 or more.
module ofs_prog_ctrl
    import ofs_prog_pkg::*;
#(
    parameter int DEPTH     = 512,
    parameter int OFS_W     = $clog2(DEPTH),
    parameter int SYNC_STGS = 2
) (
    input  logic             clk_a,
    input  logic             clk_c,
    input  logic             mrst_n,
    input  logic             spm_sel,
    input  logic             fs0_sd,
    input  logic             fs1_sen,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_data_lo,
    output logic             fifo_wr,
    output logic             ir_a,
    output logic             ir_c,
    output logic             cfg_err,
    output logic [OFS_W-1:0] y1_ofs,
    output logic [OFS_W-1:0] x1_ofs,
    output logic [OFS_W-1:0] y2_ofs,
    output logic [OFS_W-1:0] x2_ofs
);

    localparam int VW = OFS_SLOTS * OFS_W;

    ld_mode_e         dec_mode;
    logic [OFS_W-1:0] dec_preset;
    logic             dec_rsv;
    logic [VW-1:0]    ofs_vec;
    logic             done_a;
    logic             par_mode;

    ofs_mode_decode #(.OW(OFS_W)) u_dec (
        .spm    (spm_sel),
        .fs1    (fs1_sen),
        .fs0    (fs0_sd),
        .mode   (dec_mode),
        .preset (dec_preset),
        .rsv    (dec_rsv)
    );

    ofs_load_ctrl #(.OW(OFS_W), .SLOTS(OFS_SLOTS)) u_load (
        .clk        (clk_a),
        .rst_n      (mrst_n),
        .dec_mode   (dec_mode),
        .dec_preset (dec_preset),
        .dec_rsv    (dec_rsv),
        .wr_en      (wr_en),
        .wr_bits    (wr_data_lo),
        .sd         (fs0_sd),
        .sen_n      (fs1_sen),
        .ofs_vec    (ofs_vec),
        .done       (done_a),
        .ir         (ir_a),
        .fifo_wr    (fifo_wr),
        .cfg_err    (cfg_err),
        .par_mode   (par_mode)
    );

    ofs_done_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk   (clk_c),
        .rst_n (mrst_n),
        .d     (done_a),
        .q     (ir_c)
    );

    assign {y1_ofs, x1_ofs, y2_ofs, x2_ofs} = ofs_vec;

endmodule

// File: rtl/ofs_prog_chk.sv
// Module: property checker for the offset loader, bound into the top module.
// Assumes the internal done and parallel-mode nets of the top are visible.
module ofs_prog_chk #(
    parameter int OW = 9
) (
    input logic          clk_a,
    input logic          clk_c,
    input logic          mrst_n,
    input logic          done_a,
    input logic          par_mode,
    input logic          ir_a,
    input logic          ir_c,
    input logic          cfg_err,
    input logic [OW-1:0] y1,
    input logic [OW-1:0] x1,
    input logic [OW-1:0] y2,
    input logic [OW-1:0] x2
);

    AST_DONE_STICKY: assert property (@(posedge clk_a) disable iff (!mrst_n)
        done_a |=> done_a); // R8

    AST_OFS_FROZEN: assert property (@(posedge clk_a) disable iff (!mrst_n)
        done_a |=> $stable({y1, x1, y2, x2})); // R8

    AST_IRC_AFTER_DONE: assert property (@(posedge clk_c) disable iff (!mrst_n)
        $rose(ir_c) |-> done_a); // R7

    AST_IRA_GATED: assert property (@(posedge clk_a) disable iff (!mrst_n)
        ir_a |-> (done_a || par_mode)); // R5

    AST_RSV_EIGHT: assert property (@(posedge clk_a) disable iff (!mrst_n)
        (cfg_err && done_a) |-> ({y1, x1, y2, x2} == {4{OW'(8)}})); // R6

endmodule

bind ofs_prog_ctrl ofs_prog_chk #(.OW(OFS_W)) u_chk (
    .clk_a    (clk_a),
    .clk_c    (clk_c),
    .mrst_n   (mrst_n),
    .done_a   (done_a),
    .par_mode (par_mode),
    .ir_a     (ir_a),
    .ir_c     (ir_c),
    .cfg_err  (cfg_err),
    .y1       (y1_ofs),
    .x1       (x1_ofs),
    .y2       (y2_ofs),
    .x2       (x2_ofs)
);

// File: tb/sim_ofs_prog_ctrl.sv
// Bench: scoreboard-based test of the offset loader. Session tasks push the
// expected offsets and error flag; a monitor pops and compares them when the
// FIFO2 input-ready rises.
module sim_ofs_prog_ctrl;

    localparam int DEPTH = 512;
    localparam int OW    = 9;
    localparam int VW    = 4 * OW;

    logic          clk_a = 1'b0;
    logic          clk_c = 1'b0;
    logic          mrst_n = 1'b0;
    logic          spm_sel = 1'b1;
    logic          fs0_sd = 1'b0;
    logic          fs1_sen = 1'b1;
    logic          wr_en = 1'b0;
    logic [OW-1:0] wr_data_lo = '0;
    logic          fifo_wr, ir_a, ir_c, cfg_err;
    logic [OW-1:0] y1_ofs, x1_ofs, y2_ofs, x2_ofs;

    typedef struct {
        string       req;
        logic [VW:0] v;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_fail = 0;

    ofs_prog_ctrl #(.DEPTH(DEPTH)) u0 (
        .clk_a(clk_a), .clk_c(clk_c), .mrst_n(mrst_n), .spm_sel(spm_sel),
        .fs0_sd(fs0_sd), .fs1_sen(fs1_sen), .wr_en(wr_en), .wr_data_lo(wr_data_lo),
        .fifo_wr(fifo_wr), .ir_a(ir_a), .ir_c(ir_c), .cfg_err(cfg_err),
        .y1_ofs(y1_ofs), .x1_ofs(x1_ofs), .y2_ofs(y2_ofs), .x2_ofs(x2_ofs)
    );

    always #5 clk_a = ~clk_a;
    always #7 clk_c = ~clk_c;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [VW:0] pack4(input logic err, input int a, input int b,
                                          input int c, input int d);
        return {err, a[OW-1:0], b[OW-1:0], c[OW-1:0], d[OW-1:0]};
    endfunction

    // Monitor: compare the scoreboard head when FIFO2 becomes ready.
    initial begin
        forever begin
            @(posedge ir_c);
            @(negedge clk_a);
            if (sb_q.size() == 0) begin
                check("R7 ready raised with no session pending", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.req, {cfg_err, y1_ofs, x1_ofs, y2_ofs, x2_ofs}, e.v);
            end
        end
    end

    // Driver: hold reset with the given straps, push expectation, release.
    task automatic start_session(input logic spm, input logic fs1, input logic fs0,
                                 input string req, input logic [VW:0] expv);
        exp_t e;
        @(negedge clk_a);
        mrst_n  = 1'b0;
        spm_sel = spm;
        fs1_sen = fs1;
        fs0_sd  = fs0;
        wr_en   = 1'b1;
        repeat (6) @(negedge clk_a);
        check("R1 ir_a low in reset", ir_a, 0);
        check("R1 ir_c low in reset", ir_c, 0);
        check("R1 fifo_wr blocked in reset", fifo_wr, 0);
        wr_en = 1'b0;
        e.req = req;
        e.v   = expv;
        sb_q.push_back(e);
        mrst_n = 1'b1;
    endtask

    initial begin
        logic [VW-1:0] stream;
        int            pv [4];

        // Preset 64, then strap changes after release (R9).
        start_session(1, 1, 1, "R2 preset 64", pack4(0, 64, 64, 64, 64));
        @(negedge clk_a);
        check("R2 ir_a low one edge after release", ir_a, 0);
        check("R7 ir_c low just after done", ir_c, 0);
        @(negedge clk_a);
        check("R2 ir_a high two edges after release", ir_a, 1);
        repeat (2) @(negedge clk_a);
        check("R7 ir_c high two clk_c edges after done", ir_c, 1);
        spm_sel = 1'b0; fs1_sen = 1'b0; fs0_sd = 1'b1;
        repeat (3) @(negedge clk_a);
        check("R9 offsets ignore strap changes", {y1_ofs, x1_ofs, y2_ofs, x2_ofs},
              pack4(0, 64, 64, 64, 64) & {1'b0, {VW{1'b1}}});
        check("R9 cfg_err ignores strap changes", cfg_err, 0);

        start_session(1, 1, 0, "R2 preset 16", pack4(0, 16, 16, 16, 16));
        repeat (5) @(negedge clk_a);
        check("R2 ir_a after preset 16", ir_a, 1);
        start_session(1, 0, 1, "R2 preset 8", pack4(0, 8, 8, 8, 8));
        repeat (5) @(negedge clk_a);

        // Parallel load over the first four writes.
        pv = '{17, 200, 3, 450};
        start_session(1, 0, 0, "R3 parallel order Y1 X1 Y2 X2", pack4(0, 17, 200, 3, 450));
        @(negedge clk_a);
        check("R3 ir_a high right after release", ir_a, 1);
        check("R7 ir_c low before parallel done", ir_c, 0);
        for (int i = 0; i < 4; i++) begin
            wr_en = 1'b1;
            wr_data_lo = OW'(pv[i]);
            #1 check("R3 programming write kept from memory", fifo_wr, 0);
            @(negedge clk_a);
            wr_en = 1'b0;
            @(negedge clk_a);
        end
        wr_en = 1'b1;
        wr_data_lo = OW'(7);
        #1 check("R3 fifth write reaches memory", fifo_wr, 1);
        @(negedge clk_a);
        wr_en = 1'b0;
        repeat (4) @(negedge clk_a);
        check("R7 ir_c high after parallel done", ir_c, 1);
        check("R8 offsets unchanged by later write", {y1_ofs, x1_ofs, y2_ofs, x2_ofs},
              pack4(0, 17, 200, 3, 450) & {1'b0, {VW{1'b1}}});

        // Serial load with idle gaps.
        stream = pack4(0, 300, 5, 508, 1) & {1'b0, {VW{1'b1}}};
        start_session(0, 1, 0, "R4 serial stream order", pack4(0, 300, 5, 508, 1));
        for (int i = VW - 1; i >= 0; i--) begin
            if (i % 7 == 3) begin
                fs1_sen = 1'b1;
                fs0_sd  = ~stream[i];
                @(negedge clk_a);
            end
            fs1_sen = 1'b0;
            fs0_sd  = stream[i];
            wr_en   = 1'b1;
            if (i == 20) begin
                #1 check("R5 write blocked during serial load", fifo_wr, 0);
                check("R5 ir_a low during serial load", ir_a, 0);
                check("R7 ir_c low during serial load", ir_c, 0);
            end
            @(negedge clk_a);
        end
        fs1_sen = 1'b1;
        #1 check("R5 ir_a still low after last bit edge", ir_a, 0);
        check("R5 write accepted once serial done", fifo_wr, 1);
        @(negedge clk_a);
        wr_en = 1'b0;
        check("R5 ir_a high one edge after last bit", ir_a, 1);
        repeat (4) @(negedge clk_a);

        // Reserved encodings.
        start_session(0, 0, 0, "R6 reserved 000 loads 8", pack4(1, 8, 8, 8, 8));
        repeat (5) @(negedge clk_a);
        check("R6 cfg_err on reserved", cfg_err, 1);
        start_session(0, 1, 1, "R6 reserved 011 loads 8", pack4(1, 8, 8, 8, 8));
        repeat (5) @(negedge clk_a);
        check("R6 ir_a on reserved", ir_a, 1);

        repeat (5) @(negedge clk_a);
        check("R7 every session signalled ready", sb_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule